// File: doc/BRIEF.md
# Filtered Quadrature Position Counter with Index Capture

This block turns a pair of quadrature encoder signals (A and B) into a signed-agnostic position count, counting one step for every valid edge of either signal. All three encoder inputs, including the index signal Z, arrive asynchronously. Each one passes through a two-flop synchronizer and then a debounce filter before the decoder or the index detector uses it. The filter accepts a new level only after it has seen that level on seven consecutive clock samples. At a 40 MHz clock this rejects pulses shorter than 175 ns.

A host samples the position by pulsing a latch strobe. The running count is copied into a read register in a single cycle, so a read never mixes bits from before and after a count change. A rising edge of the filtered index signal copies the running count into an index register and sets a sticky flag. The host clears that flag with a strobe. The filtered levels of A, B and Z are brought out as well, so that the pins can double as plain digital inputs.

Top module: `quad_position_counter`

## Requirements
- R1: While reset is asserted, pos_o, idx_pos_o, idx_seen_o, a_lvl_o, b_lvl_o and z_lvl_o are all 0.
- R2: Each input passes through two synchronizer flops and a filter whose level flips only after FILT_LEN (7) consecutive samples that differ from it. Counting the first clock edge that samples a new raw level as edge 1, the filtered level changes on edge 9. A raw pulse of 6 clocks or fewer never reaches the filtered level or any other output.
- R3: The decoder uses the phase code {A, A xor B}, which runs 0,1,2,3 for AB = 00,01,11,10. A phase change of +1 (mod 4) increments the count by one, and a change of +3 (mod 4) decrements it by one. The count wraps modulo 2^CNT_W and updates one cycle after the filtered levels change.
- R4: When both filtered A and B change in the same sample (a phase change of 2), the count does not change.
- R5: A latch_i pulse copies the running count into pos_o at the next edge. Without a pulse, pos_o holds its value while the count moves.
- R6: On a rising edge of filtered Z, idx_pos_o takes the running count and idx_seen_o is set, one cycle after the filtered level rises. A falling edge captures nothing.
- R7: An idx_clr_i pulse clears idx_seen_o at the next edge. If a set and a clear fall on the same edge, the set wins.
- R8: a_lvl_o, b_lvl_o and z_lvl_o show the filtered levels of A, B and Z.
- R9: The counter follows more than 8191 consecutive steps between reads without losing count, and it wraps through zero in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| qa_i | input | 1 | Asynchronous quadrature A |
| qb_i | input | 1 | Asynchronous quadrature B |
| qz_i | input | 1 | Asynchronous index Z |
| latch_i | input | 1 | Host strobe: copy running count to pos_o |
| idx_clr_i | input | 1 | Host strobe: clear index flag |
| pos_o | output | CNT_W | Latched position |
| idx_pos_o | output | CNT_W | Count captured at the last index rising edge |
| idx_seen_o | output | 1 | Sticky index flag |
| a_lvl_o | output | 1 | Filtered A level |
| b_lvl_o | output | 1 | Filtered B level |
| z_lvl_o | output | 1 | Filtered Z level |

## Verification
The bench builds the block with CNT_W = 14 and the default filter length of 7 and synchronizer depth of 2. The narrow counter lets a run of more than 8191 steps and a wrap below zero fit inside the cycle budget. It also keeps every full-range value an exact modular check. With the default filter length, the bench can probe the latency edge by edge and compare 6-clock and 7-clock pulses on Z and A. It also aligns a clear strobe exactly with the index set cycle.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_t;

  // phase code: 00->0, 01->1, 11->2, 10->3
  function automatic logic [1:0] quad_phase(input logic a, input logic b);
    return {a, a ^ b};
  endfunction

  function automatic step_t quad_step(input logic pa, input logic pb,
                                      input logic a,  input logic b);
    logic [1:0] diff;
    diff = quad_phase(a, b) - quad_phase(pa, pb);
    case (diff)
      2'd1:    return STEP_UP;
      2'd3:    return STEP_DOWN;
      default: return STEP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/qpc_rst_sync.sv
module qpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          run_q, run_d;
  logic                   lvl_q, lvl_d;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
    run_d  = run_q;
    lvl_d  = lvl_q;
    if (smp == lvl_q) begin
      run_d = '0;
    end else if (run_q == RUN_LAST) begin
      run_d = '0;
      lvl_d = smp;
    end else begin
      run_d = run_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      run_q  <= run_d;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  // R2: a new filtered level must agree with the synchronized sample behind it
  p_filter_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(smp) == lvl_q));

  // R2: the filtered level never flips while the sample agrees with it
  p_filter_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp == lvl_q) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
  import qpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_i,
  input  logic             b_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             a_q, b_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  step_t            step;

  always_comb begin
    step  = quad_step(a_q, b_q, a_i, b_i);
    cnt_d = cnt_q;
    case (step)
      STEP_UP:   cnt_d = cnt_q + CNT_W'(1);
      STEP_DOWN: cnt_d = cnt_q - CNT_W'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      a_q   <= a_i;
      b_q   <= b_i;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R3: the count moves by exactly one step at a time
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |->
      (((cnt_q - $past(cnt_q)) == CNT_W'(1)) || (($past(cnt_q) - cnt_q) == CNT_W'(1))));

  // R3: no input change, no count change
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i == a_q) && (b_i == b_q)) |=> $stable(cnt_q));

  // R4: simultaneous change of A and B leaves the count alone
  p_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i != a_q) && (b_i != b_q)) |=> $stable(cnt_q));
endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 7
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             qa_i,
  input  logic             qb_i,
  input  logic             qz_i,
  input  logic             latch_i,
  input  logic             idx_clr_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] idx_pos_o,
  output logic             idx_seen_o,
  output logic             a_lvl_o,
  output logic             b_lvl_o,
  output logic             z_lvl_o
);
  localparam int N_IN = 3;

  logic             rst_n;
  logic [N_IN-1:0]  raw_vec, lvl_vec;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] pos_q, pos_d, idx_pos_q, idx_pos_d;
  logic             seen_q, seen_d, z_prev_q;
  logic             z_rise;

  qpc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  assign raw_vec = {qz_i, qb_i, qa_i};

  for (genvar i = 0; i < N_IN; i++) begin : g_filt
    qpc_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_vec[i]), .lvl_o(lvl_vec[i]));
  end

  qpc_decoder #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .a_i(lvl_vec[0]), .b_i(lvl_vec[1]), .cnt_o(count));

  assign z_rise = lvl_vec[2] & ~z_prev_q;

  always_comb begin
    pos_d     = latch_i ? count : pos_q;
    idx_pos_d = z_rise  ? count : idx_pos_q;
    seen_d    = seen_q;
    if (idx_clr_i) seen_d = 1'b0;
    if (z_rise)    seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      idx_pos_q <= '0;
      seen_q    <= 1'b0;
      z_prev_q  <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      idx_pos_q <= idx_pos_d;
      seen_q    <= seen_d;
      z_prev_q  <= lvl_vec[2];
    end
  end

  assign pos_o      = pos_q;
  assign idx_pos_o  = idx_pos_q;
  assign idx_seen_o = seen_q;
  assign a_lvl_o    = lvl_vec[0];
  assign b_lvl_o    = lvl_vec[1];
  assign z_lvl_o    = lvl_vec[2];

  // R5: latch copies the running count
  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> (pos_o == $past(count)));

  // R5: no latch, read value holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(pos_o));

  // R6: index rising edge captures the count and raises the flag
  p_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    z_rise |=> (idx_seen_o && (idx_pos_o == $past(count))));

  // R7: a clear without a simultaneous set drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_clr_i && !z_rise) |=> !idx_seen_o);
endmodule

// File: tb/quad_position_counter_tb.sv
module quad_position_counter_tb;
  localparam int CW  = 14;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic arst_n, ra, rb, rz, latch, clr;
  logic [CW-1:0] pos, ipos;
  logic seen, al, bl, zl;
  int checks = 0, errors = 0, exp_pos = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_position_counter #(.CNT_W(CW)) u_dut (
    .clk(clk), .arst_n(arst_n), .qa_i(ra), .qb_i(rb), .qz_i(rz),
    .latch_i(latch), .idx_clr_i(clr), .pos_o(pos), .idx_pos_o(ipos),
    .idx_seen_o(seen), .a_lvl_o(al), .b_lvl_o(bl), .z_lvl_o(zl));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic move(input int dir);
    int ph;
    ph = ((ra ? 2 : 0) + ((ra ^ rb) ? 1 : 0) + dir + 4) % 4;
    ra = (ph >= 2);
    rb = ra ^ ph[0];
    exp_pos = (exp_pos + dir + MOD) % MOD;
    tick(10);
  endtask

  task automatic do_latch(input string req);
    latch = 1'b1; tick(1); latch = 1'b0;
    chk(req, int'(pos), exp_pos);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    arst_n = 1'b0; ra = 0; rb = 0; rz = 0; latch = 0; clr = 0;
    tick(3);
    // R1 reset state
    chk("R1 pos", int'(pos), 0);
    chk("R1 idx_pos", int'(ipos), 0);
    chk("R1 seen", int'(seen), 0);
    chk("R1 levels", int'({al, bl, zl}), 0);
    arst_n = 1'b1;
    tick(5);

    // R2/R8 exact latency on A: 00 -> 10 is phase 0 -> 3, a decrement
    ra = 1'b1;
    tick(8);
    chk("R2 a_lvl before edge 9", int'(al), 0);
    tick(1);
    chk("R2 R8 a_lvl at edge 9", int'(al), 1);
    exp_pos = MOD - 1;
    tick(4);
    do_latch("R3 R9 first decrement wraps");

    // R3 sweep: eight steps each way, all phase transitions
    for (int i = 0; i < 8; i++) begin
      move(1);
      do_latch("R3 forward step");
      chk("R8 b_lvl", int'(bl), int'(rb));
    end
    for (int i = 0; i < 8; i++) begin
      move(-1);
      do_latch("R3 backward step");
      chk("R8 a_lvl", int'(al), int'(ra));
    end

    // R4 both signals toggle together
    ra = ~ra; rb = ~rb;
    tick(12);
    do_latch("R4 invalid transition ignored");
    chk("R8 levels after double change", int'({al, bl}), int'({ra, rb}));
    move(1);
    do_latch("R3 step after invalid");

    // R2 six-clock glitch on A never passes
    held = int'(al);
    ra = ~ra; tick(6); ra = ~ra;
    for (int i = 0; i < 14; i++) begin
      tick(1);
      chk("R2 A glitch rejected", int'(al), held);
    end
    do_latch("R2 count unchanged by glitch");

    // R2 six-clock glitch on Z: no index
    rz = 1'b1; tick(6); rz = 1'b0; tick(14);
    chk("R2 Z glitch no index", int'(seen), 0);
    chk("R2 Z glitch z_lvl", int'(zl), 0);

    // R6 seven-clock pulse passes and captures the count
    rz = 1'b1; tick(7); rz = 1'b0; tick(14);
    chk("R6 index flag set", int'(seen), 1);
    chk("R6 index position", int'(ipos), exp_pos);
    held = exp_pos;

    // R7 clear
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R7 clear flag", int'(seen), 0);
    // R6 falling edge captured nothing; moves do not disturb idx_pos
    move(1); move(1);
    chk("R6 idx_pos held", int'(ipos), held);
    chk("R6 no set on fall", int'(seen), 0);
    // R5 no latch: pos_o keeps old value
    chk("R5 pos held without latch", int'(pos), (exp_pos - 2 + MOD) % MOD);
    do_latch("R5 latch after moves");

    // R7 clear on the same edge as set: set wins
    rz = 1'b1;
    tick(9);
    clr = 1'b1; tick(1); clr = 1'b0;
    chk("R7 set wins over clear", int'(seen), 1);
    chk("R6 capture on held Z", int'(ipos), exp_pos);
    chk("R8 z_lvl", int'(zl), 1);
    rz = 1'b0; tick(12);

    // R9 long run and wrap below zero
    held = exp_pos;
    for (int i = 0; i < held + 3; i++) move(-1);
    do_latch("R9 wrap below zero");
    for (int i = 0; i < 8200; i++) move(1);
    do_latch("R9 more than 8191 steps tracked");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule